// File: doc/BRIEF.md
# DRAM Refresh and Start-up Sequencer

This block keeps an asynchronous dynamic RAM alive. After reset it holds off for a programmable start-up delay. It then runs a fixed burst of warm-up refresh cycles, and only after that does it tell the access controller that normal accesses may begin. From then on, an interval timer adds one owed refresh to a backlog every period. The sequencer pays off the backlog one refresh cycle at a time. Each refresh cycle uses either the strobe-order style (column strobe low before row strobe, no address) or the row-address style (column strobe high, with the row taken from an internal wrapping counter).

The sequencer shares the memory pins with an access controller. It raises `req` and waits for `grant`. It drives the strobes only while it owns the bus (`bus_own`). When the backlog is full and the sequencer is still waiting, it raises `close_page` so that the controller ends its open page. Every timing value is given in clock cycles. At 250 MHz the defaults give 200 µs of start-up, a 15.6 µs interval, 12 ns of setup, a 72 ns strobe and 52 ns of recovery. The parameters must satisfy INIT_CNT <= PEND_MAX and RECOVER_CYC >= 2.

States and transitions:
- BOOT → IDLE when the start-up timer expires. This transition also loads the backlog with INIT_CNT.
- IDLE → ASK when the backlog is non-zero.
- ASK → SETUP on `grant`. This transition also samples `style_sel`.
- SETUP → STROBE after SETUP_CYC cycles.
- STROBE → RECOVER after STROBE_CYC cycles.
- RECOVER → ASK after RECOVER_CYC cycles if any refresh is still owed, otherwise RECOVER → IDLE.

Top module: `dref_seq`

## Requirements
- R1: While reset is held, `req`, `bus_own`, `addr_en`, `init_done` and `close_page` are 0, and `ras_n`, `cas_n` and `we_n` are 1.
- R2: `req` stays 0 for the first STARTUP_CYC cycles after reset is released.
- R3: `init_done` rises at the end of the INIT_CNT-th refresh cycle and stays high until reset.
- R4: `bus_own` becomes 1 only in the cycle after `grant` was seen while `req` was high. An ungranted `req` stays high.
- R5: A strobe-order refresh (`style_sel`=0) has three phases. First come SETUP_CYC cycles with `cas_n`=0 and `ras_n`=1. Then come STROBE_CYC cycles with both strobes at 0. Then come RECOVER_CYC cycles with both strobes at 1. `we_n` is 1 throughout.
- R6: A row-address refresh (`style_sel`=1) keeps `cas_n`=1. `addr_en`=1 and `row_addr` is stable through the setup and strobe phases.
- R7: `row_addr` advances by one after each row-address refresh and wraps from 2^ROW_W-1 to 0. Strobe-order refreshes leave it unchanged.
- R8: Once `init_done` is high, one refresh is added to the backlog every INTERVAL_CYC cycles.
- R9: The backlog saturates at PEND_MAX, and a tick at saturation is lost. `close_page` is high while the sequencer is in ASK after `init_done` with a full backlog.
- R10: The refresh style is sampled only at the grant. Changes of `style_sel` during a cycle do not alter it.
- R11: If refreshes are still owed at the end of a cycle, `req` stays high without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| style_sel | input | 1 | 0 = strobe-order refresh, 1 = row-address refresh |
| grant | input | 1 | Bus granted by access controller |
| req | output | 1 | Bus request |
| close_page | output | 1 | Controller must close its page |
| init_done | output | 1 | Warm-up complete, accesses allowed |
| bus_own | output | 1 | Sequencer is driving the memory pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr_en | output | 1 | Row address valid on the bus |
| row_addr | output | ROW_W | Row counter for row-address refresh |

## Verification
The bound checker watches four rules on every cycle:
- the strobe ordering at each row-strobe fall, for both styles;
- that ownership of the bus follows a grant;
- that the row counter only ever steps by one;
- that the backlog never exceeds its bound.

The exact phase lengths, the start-up hold, the warm-up count, the interval arithmetic, saturation and `close_page`, and the sampling of the style at the grant can only be shown by the bench's reference model. The model is compared against the design cycle by cycle, under immediate and delayed grants, a long denial, and a style input that toggles.

// File: rtl/dref_pkg.sv
package dref_pkg;
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_ASK,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER
    } dref_state_e;

    typedef enum logic {
        STYLE_CBR     = 1'b0,
        STYLE_ROWADDR = 1'b1
    } dref_style_e;
endpackage

// File: rtl/dref_tick_timer.sv
module dref_tick_timer #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dref_backlog.sv
module dref_backlog #(
    parameter int MAXV = 8,
    parameter int LOADV = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic                          inc,
    input  logic                          dec,
    output logic [$clog2(MAXV+1)-1:0]     count,
    output logic                          full,
    output logic                          empty
);
    localparam int CW = $clog2(MAXV + 1);
    localparam logic [CW-1:0] TOP  = CW'(MAXV);
    localparam logic [CW-1:0] INIT = CW'(LOADV);

    logic [CW-1:0] cnt_q;

    assign count = cnt_q;
    assign full  = (cnt_q == TOP);
    assign empty = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= INIT;
        end else if (inc && !dec) begin
            if (!full) cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc) begin
            if (!empty) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/dref_row_ctr.sv
module dref_row_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] row
);
    logic [W-1:0] row_q;

    assign row = row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (step) begin
            row_q <= row_q + 1'b1;
        end
    end
endmodule

// File: rtl/dref_seq.sv
module dref_seq
    import dref_pkg::*;
#(
    parameter int STARTUP_CYC  = 50000,
    parameter int INIT_CNT     = 8,
    parameter int INTERVAL_CYC = 3900,
    parameter int PEND_MAX     = 8,
    parameter int ROW_W        = 12,
    parameter int SETUP_CYC    = 3,
    parameter int STROBE_CYC   = 18,
    parameter int RECOVER_CYC  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             style_sel,
    input  logic             grant,
    output logic             req,
    output logic             close_page,
    output logic             init_done,
    output logic             bus_own,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             addr_en,
    output logic [ROW_W-1:0] row_addr
);
    localparam int PH_MAX0 = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int PH_MAX  = (PH_MAX0 > RECOVER_CYC) ? PH_MAX0 : RECOVER_CYC;
    localparam int PH_W    = $clog2(PH_MAX + 1);
    localparam int PEND_W  = $clog2(PEND_MAX + 1);
    localparam logic [PH_W-1:0] PH_SETUP   = PH_W'(SETUP_CYC - 1);
    localparam logic [PH_W-1:0] PH_STROBE  = PH_W'(STROBE_CYC - 1);
    localparam logic [PH_W-1:0] PH_RECOVER = PH_W'(RECOVER_CYC - 1);

    dref_state_e       state_q, state_d;
    logic [PH_W-1:0]   ph_q, ph_d;
    dref_style_e       style_q, style_d;
    logic              init_q;
    logic              boot_tick, per_tick;
    logic              ph_zero, cycle_end, more_left;
    logic [PEND_W-1:0] pend_q;
    logic              pend_full, pend_empty;

    dref_tick_timer #(.PERIOD(STARTUP_CYC)) u_boot_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == ST_BOOT),
        .tick  (boot_tick)
    );

    dref_tick_timer #(.PERIOD(INTERVAL_CYC)) u_period_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_q),
        .tick  (per_tick)
    );

    dref_backlog #(.MAXV(PEND_MAX), .LOADV(INIT_CNT)) u_backlog (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (boot_tick),
        .inc   (per_tick),
        .dec   (cycle_end),
        .count (pend_q),
        .full  (pend_full),
        .empty (pend_empty)
    );

    dref_row_ctr #(.W(ROW_W)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (cycle_end && (style_q == STYLE_ROWADDR)),
        .row   (row_addr)
    );

    assign ph_zero   = (ph_q == '0);
    assign cycle_end = (state_q == ST_RECOVER) && ph_zero;
    assign more_left = (pend_q > PEND_W'(1)) || per_tick;

    // Next-state and phase-length selection
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        style_d = style_q;
        unique case (state_q)
            ST_BOOT: begin
                if (boot_tick) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!pend_empty) state_d = ST_ASK;
            end
            ST_ASK: begin
                if (grant) begin
                    state_d = ST_SETUP;
                    ph_d    = PH_SETUP;
                    style_d = dref_style_e'(style_sel);
                end
            end
            ST_SETUP: begin
                if (ph_zero) begin
                    state_d = ST_STROBE;
                    ph_d    = PH_STROBE;
                end else begin
                    ph_d = ph_q - 1'b1;
                end
            end
            ST_STROBE: begin
                if (ph_zero) begin
                    state_d = ST_RECOVER;
                    ph_d    = PH_RECOVER;
                end else begin
                    ph_d = ph_q - 1'b1;
                end
            end
            ST_RECOVER: begin
                if (ph_zero) begin
                    state_d = more_left ? ST_ASK : ST_IDLE;
                end else begin
                    ph_d = ph_q - 1'b1;
                end
            end
            default: state_d = ST_BOOT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            ph_q    <= '0;
            style_q <= STYLE_CBR;
            init_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            style_q <= style_d;
            if (cycle_end && !init_q && (pend_q == PEND_W'(1))) init_q <= 1'b1;
        end
    end

    // Moore outputs
    always_comb begin
        req        = 1'b0;
        bus_own    = 1'b0;
        ras_n      = 1'b1;
        cas_n      = 1'b1;
        addr_en    = 1'b0;
        close_page = 1'b0;
        unique case (state_q)
            ST_BOOT, ST_IDLE: ;
            ST_ASK: begin
                req        = 1'b1;
                close_page = init_q && pend_full;
            end
            ST_SETUP: begin
                req     = 1'b1;
                bus_own = 1'b1;
                cas_n   = (style_q == STYLE_ROWADDR);
                addr_en = (style_q == STYLE_ROWADDR);
            end
            ST_STROBE: begin
                req     = 1'b1;
                bus_own = 1'b1;
                ras_n   = 1'b0;
                cas_n   = (style_q == STYLE_ROWADDR);
                addr_en = (style_q == STYLE_ROWADDR);
            end
            ST_RECOVER: begin
                req     = 1'b1;
                bus_own = 1'b1;
            end
            default: ;
        endcase
    end

    assign we_n      = 1'b1;
    assign init_done = init_q;
endmodule

// File: rtl/dref_seq_chk.sv
module dref_seq_chk #(
    parameter int ROW_W    = 12,
    parameter int PEND_MAX = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         grant,
    input logic                         req,
    input logic                         bus_own,
    input logic                         ras_n,
    input logic                         cas_n,
    input logic                         addr_en,
    input logic                         init_done,
    input logic [ROW_W-1:0]             row_addr,
    input logic [$clog2(PEND_MAX+1)-1:0] pend_cnt
);
    localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

    a_r4_own_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own) |-> $past(grant) && $past(req));

    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !bus_own && !grant) |=> req);

    a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

    a_r6_addr_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && addr_en) |-> $past(cas_n) && $past(addr_en));

    a_r6_cas_high_rowaddr: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en |-> cas_n);

    a_r6_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_en && $past(addr_en)) |-> $stable(row_addr));

    a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_addr) |-> (row_addr == $past(row_addr) + ONE));

    a_r3_init_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(bus_own) && $past(ras_n));

    a_r9_backlog_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= ($clog2(PEND_MAX+1))'(PEND_MAX));
endmodule

bind dref_seq dref_seq_chk #(.ROW_W(ROW_W), .PEND_MAX(PEND_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .req       (req),
    .bus_own   (bus_own),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .addr_en   (addr_en),
    .init_done (init_done),
    .row_addr  (row_addr),
    .pend_cnt  (pend_q)
);

// File: tb/dref_seq_tb_top.sv
module dref_seq_tb_top;
    localparam int SU = 20, INI = 8, IV = 30, PM = 8, RW = 4;
    localparam int SC = 2, AC = 3, RC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic style_sel = 1'b0;
    logic grant = 1'b0;
    logic req, close_page, init_done, bus_own, ras_n, cas_n, we_n, addr_en;
    logic [RW-1:0] row_addr;

    always #2 clk = ~clk;

    dref_seq #(.STARTUP_CYC(SU), .INIT_CNT(INI), .INTERVAL_CYC(IV), .PEND_MAX(PM),
               .ROW_W(RW), .SETUP_CYC(SC), .STROBE_CYC(AC), .RECOVER_CYC(RC)) dut_i (
        .clk(clk), .rst_n(rst_n), .style_sel(style_sel), .grant(grant), .req(req),
        .close_page(close_page), .init_done(init_done), .bus_own(bus_own),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr_en(addr_en), .row_addr(row_addr));

    int total = 0, bad = 0;
    bit finished = 0;
    bit allow = 1, toggle = 0;
    int delay = 0, req_age = 0;
    int seen_close = 0, seen_wrap = 0, strobes = 0, model_done = 0;
    logic [RW-1:0] last_row = '0;

    // behavioural reference model
    int m_boot, m_pend, m_tcnt, m_row;
    bit m_init, m_req, m_mode;
    int m_q[$];

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_boot = 0; m_pend = 0; m_tcnt = 0; m_row = 0;
            m_init = 0; m_req = 0; m_mode = 0; m_q.delete();
        end else begin
            bit tick, dec, load, ninit;
            int np;
            tick = m_init && (m_tcnt == IV - 1);
            dec = 0; load = 0; ninit = m_init;
            if (m_boot < SU) begin
                m_boot++;
                if (m_boot == SU) load = 1;
            end else if (m_q.size() > 0) begin
                void'(m_q.pop_front());
                if (m_q.size() == 0) dec = 1;
            end else if (m_req) begin
                if (grant) begin
                    m_mode = style_sel;
                    m_req = 0;
                    for (int i = 0; i < SC; i++) m_q.push_back(1);
                    for (int i = 0; i < AC; i++) m_q.push_back(2);
                    for (int i = 0; i < RC; i++) m_q.push_back(3);
                end
            end else if (m_pend != 0) begin
                m_req = 1;
            end
            if (load) np = INI;
            else begin
                np = m_pend + (tick ? 1 : 0) - (dec ? 1 : 0);
                if (np > PM) np = PM;
            end
            if (dec) begin
                model_done++;
                if (m_mode) m_row = (m_row + 1) % (1 << RW);
                if (!m_init && np == 0) ninit = 1;
                if (np != 0) m_req = 1;
            end
            m_tcnt = m_init ? (tick ? 0 : m_tcnt + 1) : 0;
            m_init = ninit;
            m_pend = np;
        end
    end

    // compare and drive away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit busy;
            int ph;
            busy = (m_q.size() > 0);
            ph = busy ? m_q[0] : 0;
            chk(req == (m_req || busy), (m_boot < SU) ? "R2 req" : "R4/R11 req", req, m_req || busy);
            chk(bus_own == busy, "R4 bus_own", bus_own, busy);
            chk(ras_n == !(ph == 2), toggle ? "R10 ras_n" : "R5 ras_n", ras_n, !(ph == 2));
            chk(cas_n == !(busy && !m_mode && ph != 3), toggle ? "R10 cas_n" : (m_mode ? "R6 cas_n" : "R5 cas_n"),
                cas_n, !(busy && !m_mode && ph != 3));
            chk(we_n == 1'b1, "R5 we_n", we_n, 1);
            chk(addr_en == (busy && m_mode && ph != 3), "R6 addr_en", addr_en, busy && m_mode && ph != 3);
            chk(row_addr == RW'(m_row), "R7 row_addr", row_addr, m_row);
            chk(init_done == m_init, "R3 init_done", init_done, m_init);
            chk(close_page == (m_init && m_pend == PM && m_req), "R9 close_page", close_page,
                m_init && m_pend == PM && m_req);
            if (close_page) seen_close++;
            if (row_addr == '0 && last_row == '1) seen_wrap++;
            if (bus_own && !ras_n && !dut_strobe_prev) strobes++;
            last_row = row_addr;
        end
        dut_strobe_prev = bus_own && !ras_n;
        req_age = req ? req_age + 1 : 0;
        grant <= allow && req && (req_age > delay);
        if (toggle) style_sel <= ~style_sel;
    end
    bit dut_strobe_prev = 0;

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(4);
        // R1 reset state
        chk(req == 0 && bus_own == 0 && addr_en == 0 && close_page == 0 && init_done == 0,
            "R1 reset outputs low", {req, bus_own, addr_en, close_page, init_done}, 0);
        chk(ras_n && cas_n && we_n, "R1 reset strobes high", {ras_n, cas_n, we_n}, 7);
        rst_n = 1'b1;
        run(SU - 1);
        chk(req == 0, "R2 no req during start-up", req, 0);
        run(200);
        chk(init_done == 1, "R3 warm-up complete", init_done, 1);
        // delayed grants, then count strobes against the interval
        delay = 4;
        strobes = 0;
        begin
            int d0;
            d0 = model_done;
            run(IV * 6);
            chk(strobes >= model_done - d0 && strobes <= model_done - d0 + 1,
                "R8 refreshes per interval", strobes, model_done - d0);
            chk(model_done - d0 >= 5, "R8 interval rate", model_done - d0, 6);
        end
        // long denial: backlog saturates
        allow = 0;
        run(IV * (PM + 3));
        chk(seen_close > 0, "R9 close_page seen at saturation", seen_close, 1);
        // row-address style with back-to-back drain
        style_sel = 1'b1;
        allow = 1; delay = 0;
        run(IV * 24);
        chk(seen_wrap > 0, "R7 row counter wrapped", seen_wrap, 1);
        // style input toggling during cycles
        toggle = 1;
        run(IV * 10);
        toggle = 0;
        run(10);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule